// File: doc/BRIEF.md
# Loop Counter Branch Unit

This block carries out one step of a counted-loop primitive. The primitive adjusts a register by minus one, zero or plus one, writes the result back, and branches when the result matches a chosen zero or nonzero sense. A single extension byte carries everything the step needs: the operation, the branch sense, the ninth (sign) bit of the branch displacement and the register select. A second byte supplies the low eight bits of the displacement. The fetch unit also supplies the program counter as it stands after both bytes have been fetched.

The block drives a read select into the register file from the extension byte and samples the returned value on the start cycle. On the next cycle it raises `done` for exactly one cycle. During that cycle it presents the writeback select and value, the branch decision and the branch target. Registers 0 to 2 are 8-bit wide and the rest are 16-bit wide.

The control is a two-state machine. ST_IDLE waits for work. The transition LAUNCH (start high) leads to ST_DONE. In ST_DONE, RELAUNCH (start high again) stays in ST_DONE for a back-to-back step, and RETIRE (start low) returns to ST_IDLE.

Top module: `loop_branch_unit`

## Requirements
- R1: After reset, done, wb_en, taken and illegal are all low.
- R2: ext_code[7:6] selects the operation: 00 subtracts one, 01 leaves the value unchanged, 10 adds one. The written value is the sampled register value adjusted by that amount.
- R3: Selects 0, 1 and 2 name 8-bit registers. For these, the arithmetic wraps within 8 bits, the zero test looks at 8 bits only, and wb_data[15:8] is zero.
- R4: Selects 3 to 7 name 16-bit registers. For these, the arithmetic and the zero test use all 16 bits and wrap modulo 2^16.
- R5: If ext_code[5] is 1, taken is high when the written value is nonzero. If ext_code[5] is 0, taken is high when the written value is zero. taken is only high while done is high.
- R6: target equals pc_after plus the 16-bit displacement {8 copies of ext_code[4], disp_lo}, taken modulo 2^16.
- R7: For every legal operation, wb_en is high during done whether or not the branch is taken. wb_sel equals ext_code[2:0], and rd_sel equals ext_code[2:0] combinationally.
- R8: The operation code 11 raises illegal during done and keeps both wb_en and taken low.
- R9: A start sampled at a rising edge produces done high for exactly the following cycle. Without a start, done stays low.
- R10: Starts on consecutive cycles each produce their own result on consecutive done cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch one evaluation with the operands present this cycle |
| ext_code | input | 8 | Extension byte: operation, sense, displacement sign, register select |
| disp_lo | input | 8 | Low byte of the branch displacement |
| pc_after | input | 16 | Program counter after both bytes were fetched |
| rd_sel | output | 3 | Register file read select |
| rd_data | input | 16 | Register file read data |
| done | output | 1 | One-cycle result-valid pulse |
| wb_en | output | 1 | Write the updated value back |
| wb_sel | output | 3 | Writeback register select |
| wb_data | output | 16 | Updated register value |
| taken | output | 1 | Branch taken |
| target | output | 16 | Branch target address |
| illegal | output | 1 | Invalid operation code seen |

## Verification
The bench aims at the wrap points in both widths. An 8-bit register holding 0xFF, incremented, must read as zero, and a 16-bit register must not. A design that used the full width for A, B or CCR would then report nonzero and carry into the upper byte. Decrementing 0x00 must give 0xFF on the narrow registers and 0xFFFF on the wide ones. Negative displacements and a program counter near 0x0000 or 0xFFFF expose a target adder that sign-extends from disp_lo[7] rather than from the extension bit, or that fails to wrap. The invalid operation code and back-to-back starts catch a design that writes back on a bad code or that drops or repeats a result.

// File: rtl/loop_branch_pkg.sv
package loop_branch_pkg;

    localparam int SEL_W = 3;

    typedef enum logic [1:0] {
        OP_DEC  = 2'b00,
        OP_TEST = 2'b01,
        OP_INC  = 2'b10,
        OP_BAD  = 2'b11
    } step_op_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } lbu_state_t;

    typedef struct packed {
        step_op_t         op;
        logic             sense_nz;
        logic             disp_sign;
        logic             spare;
        logic [SEL_W-1:0] sel;
    } ext_fields_t;

endpackage

// File: rtl/lbu_decode.sv
module lbu_decode
    import loop_branch_pkg::*;
#(
    parameter int NARROW_REGS = 3
) (
    input  logic [7:0]       ext,
    output ext_fields_t      fields,
    output logic             narrow,
    output logic             legal
);
    always_comb begin
        fields = ext_fields_t'(ext);
        narrow = (32'(fields.sel) < NARROW_REGS);
        legal  = (fields.op != OP_BAD);
    end
endmodule

// File: rtl/lbu_count.sv
module lbu_count
    import loop_branch_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic [DATA_W-1:0] value,
    input  step_op_t          op,
    input  logic              narrow,
    output logic [DATA_W-1:0] result,
    output logic              is_zero
);
    localparam int PAD_W = DATA_W - NARROW_W;

    logic [DATA_W-1:0]   step;
    logic [DATA_W-1:0]   wide_sum;
    logic [NARROW_W-1:0] narrow_sum;
    logic [DATA_W-1:0]   narrow_ext;

    always_comb begin
        unique case (op)
            OP_DEC:  step = '1;
            OP_INC:  step = DATA_W'(1);
            default: step = '0;
        endcase
    end

    assign wide_sum   = value + step;
    assign narrow_sum = value[NARROW_W-1:0] + step[NARROW_W-1:0];

    generate
        if (PAD_W > 0) begin : g_pad
            assign narrow_ext = {{PAD_W{1'b0}}, narrow_sum};
        end else begin : g_nopad
            assign narrow_ext = narrow_sum;
        end
    endgenerate

    always_comb begin
        if (narrow) begin
            result  = narrow_ext;
            is_zero = (narrow_sum == '0);
        end else begin
            result  = wide_sum;
            is_zero = (wide_sum == '0);
        end
    end
endmodule

// File: rtl/lbu_target.sv
module lbu_target #(
    parameter int ADDR_W = 16,
    parameter int DISP_W = 8
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic              sign,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] target
);
    localparam int HI_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] offset;

    generate
        if (HI_W > 0) begin : g_ext
            assign offset = {{HI_W{sign}}, disp};
        end else begin : g_noext
            assign offset = disp;
        end
    endgenerate

    assign target = pc + offset;
endmodule

// File: rtl/loop_branch_unit.sv
module loop_branch_unit
    import loop_branch_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int NARROW_W    = 8,
    parameter int ADDR_W      = 16,
    parameter int DISP_W      = 8,
    parameter int NARROW_REGS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        ext_code,
    input  logic [DISP_W-1:0] disp_lo,
    input  logic [ADDR_W-1:0] pc_after,
    output logic [SEL_W-1:0]  rd_sel,
    input  logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              wb_en,
    output logic [SEL_W-1:0]  wb_sel,
    output logic [DATA_W-1:0] wb_data,
    output logic              taken,
    output logic [ADDR_W-1:0] target,
    output logic              illegal
);
    lbu_state_t  state_q, state_d;
    ext_fields_t fields;
    logic        narrow, legal;
    logic [DATA_W-1:0] new_val;
    logic        new_zero;
    logic [ADDR_W-1:0] new_target;
    logic        branch_hit;

    logic              legal_q, hit_q, spare_q;
    logic [SEL_W-1:0]  sel_q;
    logic [DATA_W-1:0] val_q;
    logic [ADDR_W-1:0] tgt_q;

    lbu_decode #(.NARROW_REGS(NARROW_REGS)) u_dec (
        .ext    (ext_code),
        .fields (fields),
        .narrow (narrow),
        .legal  (legal)
    );

    lbu_count #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_cnt (
        .value   (rd_data),
        .op      (fields.op),
        .narrow  (narrow),
        .result  (new_val),
        .is_zero (new_zero)
    );

    lbu_target #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_tgt (
        .pc     (pc_after),
        .sign   (fields.disp_sign),
        .disp   (disp_lo),
        .target (new_target)
    );

    assign rd_sel     = fields.sel;
    assign branch_hit = legal && (fields.sense_nz ? !new_zero : new_zero);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_DONE;
            ST_DONE: state_d = start ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            legal_q <= 1'b1;
            hit_q   <= 1'b0;
            spare_q <= 1'b0;
            sel_q   <= '0;
            val_q   <= '0;
            tgt_q   <= '0;
        end else if (start) begin
            legal_q <= legal;
            hit_q   <= branch_hit;
            spare_q <= fields.spare;
            sel_q   <= fields.sel;
            val_q   <= new_val;
            tgt_q   <= new_target;
        end
    end

    always_comb begin
        done    = 1'b0;
        wb_en   = 1'b0;
        taken   = 1'b0;
        illegal = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_DONE: begin
                done    = 1'b1;
                wb_en   = legal_q;
                taken   = hit_q && legal_q;
                illegal = !legal_q;
            end
            default: ;
        endcase
        wb_sel  = sel_q;
        wb_data = val_q;
        target  = tgt_q;
    end

    logic unused_spare;
    assign unused_spare = spare_q;
endmodule

// File: rtl/lbu_checker.sv
module lbu_checker #(
    parameter int DATA_W      = 16,
    parameter int NARROW_W    = 8,
    parameter int NARROW_REGS = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [7:0]        ext_code,
    input logic              done,
    input logic              wb_en,
    input logic [2:0]        wb_sel,
    input logic [DATA_W-1:0] wb_data,
    input logic              taken,
    input logic              illegal,
    input logic              unused_spare
);
    a_r9_done_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    a_r9_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);

    a_r8_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!wb_en && !taken));

    a_r7_wb_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done);

    a_r5_taken_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> done);

    a_r7_sel_follows_ext: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (wb_sel == $past(ext_code[2:0])));

    a_r8_illegal_from_code: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (illegal == ($past(ext_code[7:6]) == 2'b11)));

    a_r3_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && (32'(wb_sel) < NARROW_REGS)) |-> (wb_data[DATA_W-1:NARROW_W] == '0));

    logic unused_ok;
    assign unused_ok = unused_spare;
endmodule

bind loop_branch_unit lbu_checker #(
    .DATA_W(DATA_W), .NARROW_W(NARROW_W), .NARROW_REGS(NARROW_REGS)
) u_lbu_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .ext_code(ext_code),
    .done(done), .wb_en(wb_en), .wb_sel(wb_sel), .wb_data(wb_data),
    .taken(taken), .illegal(illegal), .unused_spare(unused_spare)
);

// File: tb/tb_loop_branch_unit.sv
module tb_loop_branch_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  ext_code = '0;
    logic [7:0]  disp_lo = '0;
    logic [15:0] pc_after = '0;
    logic [2:0]  rd_sel;
    logic [15:0] rd_data;
    logic        done, wb_en, taken, illegal;
    logic [2:0]  wb_sel;
    logic [15:0] wb_data, target;
    logic [15:0] regs [8];

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    assign rd_data = regs[rd_sel];

    loop_branch_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ext_code(ext_code),
        .disp_lo(disp_lo), .pc_after(pc_after), .rd_sel(rd_sel),
        .rd_data(rd_data), .done(done), .wb_en(wb_en), .wb_sel(wb_sel),
        .wb_data(wb_data), .taken(taken), .target(target), .illegal(illegal)
    );

    function automatic logic [15:0] m_val(input logic [7:0] e, input logic [15:0] d);
        logic [15:0] delta;
        logic [7:0]  n;
        delta = (e[7:6] == 2'b00) ? 16'hFFFF : (e[7:6] == 2'b10) ? 16'h0001 : 16'h0000;
        if (e[2:0] < 3) begin
            n = d[7:0] + delta[7:0];
            return {8'h00, n};
        end
        return d + delta;
    endfunction

    function automatic logic m_taken(input logic [7:0] e, input logic [15:0] d);
        logic z;
        if (e[7:6] == 2'b11) return 1'b0;
        z = (m_val(e, d) == 16'h0000);
        return e[5] ? !z : z;
    endfunction

    function automatic logic [15:0] m_target(input logic [7:0] e, input logic [7:0] o,
                                             input logic [15:0] p);
        return p + {{8{e[4]}}, o};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_result(input logic [7:0] e, input logic [7:0] o,
                                input logic [15:0] p, input logic [15:0] d);
        logic bad_op;
        bad_op = (e[7:6] == 2'b11);
        chk("R9 done pulse", 32'(done), 32'd1);
        chk("R8 illegal flag", 32'(illegal), 32'(bad_op));
        chk("R7 wb_en", 32'(wb_en), 32'(!bad_op));
        chk("R7 wb_sel", 32'(wb_sel), 32'(e[2:0]));
        if (!bad_op) begin
            if (e[2:0] < 3) chk("R3 narrow value", 32'(wb_data), 32'(m_val(e, d)));
            else            chk("R4 wide value", 32'(wb_data), 32'(m_val(e, d)));
            chk("R2 op value", 32'(wb_data), 32'(m_val(e, d)));
        end
        chk("R5 taken", 32'(taken), 32'(m_taken(e, d)));
        chk("R6 target", 32'(target), 32'(m_target(e, o, p)));
    endtask

    task automatic launch(input logic [7:0] e, input logic [7:0] o, input logic [15:0] p,
                          input logic [15:0] d);
        @(negedge clk);
        ext_code = e; disp_lo = o; pc_after = p; regs[e[2:0]] = d; start = 1'b1;
        #1;
        chk("R7 rd_sel", 32'(rd_sel), 32'(e[2:0]));
    endtask

    task automatic run_one(input logic [7:0] e, input logic [7:0] o, input logic [15:0] p,
                           input logic [15:0] d);
        launch(e, o, p, d);
        @(negedge clk);
        start = 1'b0;
        check_result(e, o, p, d);
        @(negedge clk);
        chk("R9 done low after pulse", 32'(done), 32'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [7:0]  e0, e1, o0, o1;
        logic [15:0] p0, p1, d0, d1;
        int unused_seed;
        unused_seed = $urandom(32'd1234);
        for (int i = 0; i < 8; i++) regs[i] = 16'(i * 16'h1111);
        repeat (3) @(negedge clk);
        chk("R1 done at reset", 32'(done), 32'd0);
        chk("R1 wb_en at reset", 32'(wb_en), 32'd0);
        chk("R1 taken at reset", 32'(taken), 32'd0);
        chk("R1 illegal at reset", 32'(illegal), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 no start no done", 32'(done), 32'd0);

        // R3: narrow wrap up and down, upper byte of source ignored
        run_one(8'b10_1_0_0_000, 8'h10, 16'h1000, 16'hAAFF);
        run_one(8'b00_1_0_0_001, 8'h10, 16'h1000, 16'h5500);
        run_one(8'b10_0_0_0_010, 8'h02, 16'h2000, 16'h00FF);
        // R4: wide wrap, no narrow shortcut
        run_one(8'b10_0_0_0_100, 8'h05, 16'h3000, 16'h00FF);
        run_one(8'b10_0_0_0_101, 8'h05, 16'h3000, 16'hFFFF);
        run_one(8'b00_0_0_0_110, 8'h05, 16'h3000, 16'h0001);
        run_one(8'b00_1_0_0_111, 8'h05, 16'h3000, 16'h0000);
        run_one(8'b01_0_1_0_011, 8'h80, 16'h4000, 16'h0000);
        // R6: sign from extension bit, wrap of target
        run_one(8'b01_1_1_0_101, 8'h00, 16'h0005, 16'h1234);
        run_one(8'b01_1_0_0_101, 8'hFF, 16'hFFF0, 16'h1234);
        run_one(8'b01_1_1_0_110, 8'h7F, 16'h0000, 16'h0000);
        // R8: invalid op code
        run_one(8'b11_1_0_0_000, 8'h10, 16'h1000, 16'h0001);
        run_one(8'b11_0_1_0_101, 8'h10, 16'h1000, 16'h0001);

        // R10: back-to-back starts
        e0 = 8'b00_0_0_0_101; o0 = 8'h20; p0 = 16'h0100; d0 = 16'h0001;
        e1 = 8'b10_1_1_0_001; o1 = 8'hF0; p1 = 16'h0200; d1 = 16'h00FE;
        launch(e0, o0, p0, d0);
        @(negedge clk);
        check_result(e0, o0, p0, d0);
        ext_code = e1; disp_lo = o1; pc_after = p1; regs[e1[2:0]] = d1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check_result(e1, o1, p1, d1);
        @(negedge clk);
        chk("R10 done ends after burst", 32'(done), 32'd0);

        for (int k = 0; k < 300; k++) begin
            run_one(8'($urandom), 8'($urandom), 16'($urandom), 16'($urandom));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule